// File: doc/BRIEF.md
# Narrow Floating-Point Multiplier

This block multiplies two short floating-point words, each holding a sign, a biased exponent and a fraction with a hidden leading one. The fraction width and the exponent width are parameters. The default is a 6-bit exponent and a 9-bit fraction, which gives a 16-bit word. The intended use is as the product stage of a multiply-accumulate datapath, for example in neural-network inference, where a narrow format saves area and raises the clock rate.

Both significands, with their hidden ones restored, are multiplied into a product of full double width. The product is then normalised and cut back to the fraction width by truncation, so the magnitude of a result never exceeds the exact product. A result exponent that falls outside the format is either clamped to the largest magnitude or flushed to zero.

The datapath has two register stages. A new operand pair can enter on every clock, and its result appears two clocks later, marked by a valid strobe.

Top module: `rp_fmul`

## Requirements
- R1: A word is {sign[15], exponent[14:9], fraction[8:0]}. When the exponent e is between 1 and 63, the word means (-1)^sign × (1 + fraction/512) × 2^(e−31). An all-ones exponent is an ordinary finite value. A word with a zero exponent means zero. For example, 1.0 is 16'h3E00, and 1.5 × 1.5 gives 16'h4040.
- R2: If either operand has a zero exponent, the result is the all-zero word (+0), whatever the signs and fractions.
- R3: The sign of any nonzero result is the XOR of the two operand signs.
- R4: The two 10-bit significands are multiplied exactly into a 20-bit product P, and the exponent is ea + eb − 31. If P[19] is set, the exponent gains 1 and the fraction is P[18:10]. Otherwise the fraction is P[17:9]. The discarded bits are dropped, which is truncation toward zero.
- R5: If the final exponent is above 63, the result saturates to the operand-XOR sign with exponent 63 and an all-ones fraction.
- R6: If the final exponent is below 1, the result is +0. A result with a zero exponent field always has a zero fraction and a zero sign.
- R7: out_valid equals in_valid from exactly two clocks earlier. Operands are accepted on every cycle, with or without gaps between them.
- R8: While rst_n is low, out_valid is 0 and result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Marks op_a and op_b as a valid pair |
| op_a | input | 16 | First operand word |
| op_b | input | 16 | Second operand word |
| out_valid | output | 1 | Marks result as valid |
| result | output | 16 | Product word |

## Verification
A wrong product bit, a wrong normalisation choice or an off-by-one exponent would show up at result two clocks after the operand pair that triggers it. That is why the sweeps cover every fraction of one operand against a dense grid of the other, and every pair of exponents. A fault in the zero, saturation or flush decisions changes the whole result word at that same fixed latency. A fault in the valid pipeline shows up when bubbles are inserted between operands, as out_valid set in the wrong cycle.

// File: rtl/rp_fmul.sv
module rp_fmul #(
  parameter int EXP_W  = 6,
  parameter int FRAC_W = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [EXP_W+FRAC_W:0]       op_a,
  input  logic [EXP_W+FRAC_W:0]       op_b,
  output logic                        out_valid,
  output logic [EXP_W+FRAC_W:0]       result
);
  localparam int W      = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int XW     = EXP_W + 2;
  localparam logic signed [XW-1:0] BIAS = XW'((1 << (EXP_W - 1)) - 1);
  localparam logic signed [XW-1:0] EMAX = XW'((1 << EXP_W) - 1);

  logic [EXP_W-1:0] ea, eb;
  assign ea = op_a[FRAC_W +: EXP_W];
  assign eb = op_b[FRAC_W +: EXP_W];

  logic signed [XW-1:0] exp_sum;
  assign exp_sum = $signed({2'b00, ea}) + $signed({2'b00, eb}) - BIAS;

  logic              v1, s1_sign, s1_zero;
  logic [PROD_W-1:0] s1_prod;
  logic signed [XW-1:0] s1_exp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1      <= 1'b0;
      s1_sign <= 1'b0;
      s1_zero <= 1'b1;
      s1_prod <= '0;
      s1_exp  <= '0;
    end else begin
      v1      <= in_valid;
      s1_sign <= op_a[W-1] ^ op_b[W-1];
      s1_zero <= (ea == '0) || (eb == '0);
      s1_prod <= {1'b1, op_a[FRAC_W-1:0]} * {1'b1, op_b[FRAC_W-1:0]};
      s1_exp  <= exp_sum;
    end
  end

  logic                 top;
  logic [FRAC_W-1:0]    frac_n;
  logic signed [XW-1:0] exp_n;
  logic                 under, over;
  logic [W-1:0]         next_res;

  assign top    = s1_prod[PROD_W-1];
  assign frac_n = top ? s1_prod[PROD_W-2 -: FRAC_W] : s1_prod[PROD_W-3 -: FRAC_W];
  assign exp_n  = s1_exp + $signed({{(XW-1){1'b0}}, top});
  assign under  = exp_n <= 0;
  assign over   = exp_n > EMAX;

  always_comb begin
    if (s1_zero || under)
      next_res = '0;
    else if (over)
      next_res = {s1_sign, {EXP_W{1'b1}}, {FRAC_W{1'b1}}};
    else
      next_res = {s1_sign, exp_n[EXP_W-1:0], frac_n};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= v1;
      result    <= next_res;
    end
  end

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  a_r2_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2 && $past(in_valid && (ea == '0 || eb == '0), 2)) |-> (result == '0));

  a_r3_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2 && $past(in_valid, 2) && result != '0)
      |-> (result[W-1] == $past(op_a[W-1] ^ op_b[W-1], 2)));

  a_r6_flush_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && result[FRAC_W +: EXP_W] == '0) |-> (result == '0));
endmodule

// File: tb/rp_fmul_test.sv
module rp_fmul_test;
  localparam int CLK_P = 10;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic out_valid;
  logic [15:0] result;

  always #(CLK_P/2) clk = ~clk;

  rp_fmul uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a),
               .op_b(op_b), .out_valid(out_valid), .result(result));

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  logic d1v = 0, d2v = 0;
  logic [15:0] d1e = '0, d2e = '0;
  string d1t = "R4", d2t = "R4";

  function automatic logic [15:0] model(input logic [15:0] a, input logic [15:0] b,
                                        output string tag);
    int ea, eb, e, p, fr;
    logic s;
    ea = int'(a[14:9]); eb = int'(b[14:9]);
    s  = a[15] ^ b[15];
    if (ea == 0 || eb == 0) begin tag = "R2"; return 16'h0000; end
    p = (512 + int'(a[8:0])) * (512 + int'(b[8:0]));
    e = ea + eb - 31;
    if (p >= 524288) begin e = e + 1; fr = (p / 1024) % 512; end
    else fr = (p / 512) % 512;
    if (e < 1) begin tag = "R6"; return 16'h0000; end
    if (e > 63) begin tag = "R5"; return {s, 6'h3F, 9'h1FF}; end
    tag = "R4";
    return {s, 6'(e), 9'(fr)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [15:0] a, input logic [15:0] b);
    string t;
    logic [15:0] e;
    @(negedge clk);
    check(out_valid == d2v, "R7", {15'd0, out_valid}, {15'd0, d2v});
    if (d2v) check(result == d2e, d2t, result, d2e);
    e = model(a, b, t);
    d2v = d1v; d2e = d1e; d2t = d1t;
    d1v = v;   d1e = e;   d1t = t;
    in_valid = v; op_a = a; op_b = b;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8", {15'd0, out_valid}, 16'd0);
    check(result == 16'h0, "R8", result, 16'h0);
    rst_n = 1'b1;
    // R1 directed values
    step(1, 16'h3E00, 16'h3E00);
    step(1, {1'b0, 6'd31, 9'd256}, {1'b0, 6'd31, 9'd256});
    step(0, '0, '0);
    step(0, '0, '0);
    check(result == 16'h4040, "R1", result, 16'h4040);
    // R4/R3: every fraction of a against a grid of b
    for (int i = 0; i < 512; i++)
      for (int j = 0; j < 512; j += 4)
        step(1, {i[0], 6'(20 + i % 24), 9'(i)}, {j[3], 6'(20 + (j/4) % 24), 9'(j)});
    // R2/R5/R6: every exponent pair, with bubbles for R7
    for (int x = 0; x < 64; x++)
      for (int y = 0; y < 64; y++) begin
        step(1, {x[1], 6'(x), 9'(x * 8 + 7)}, {y[2], 6'(y), 9'(511 - y * 5)});
        if (((x + y) % 7) == 0) step(0, 16'hFFFF, 16'hFFFF);
      end
    // R5 largest times largest, R2 zero exponent with nonzero fraction and sign
    step(1, 16'hFFFF, 16'h7FFF);
    step(1, 16'h81FF, 16'hFFFF);
    step(1, 16'h0200, 16'h0200);
    repeat (3) step(0, '0, '0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule